// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 memory interface. It leaves reset with the clock-enable pin low and the command bus idle. It waits out the clock-stabilisation period, raises clock enable, and waits again. It then walks the memory through its mandatory bring-up: two precharge-all commands, the extended and main mode-register writes, a parameterised burst of auto-refreshes and the output-driver calibration entry and exit. Finally it raises a sticky done flag. All waits are given in nanoseconds and converted to controller clock cycles at elaboration, rounded up.

The mode-register payloads come in as parameters. The sequencer forces only the bits the bring-up itself owns: DLL enable, DLL reset and the three calibration-mode bits. After done, the command pins stay at NOP with clock enable high, so normal traffic logic can take over.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset, `cke_o` stays low and the bus carries NOP (`cs_n_o`=0, `ras_n_o`=`cas_n_o`=`we_n_o`=1) for at least ceil(T_STABLE_NS/clock period) cycles.
- R2: After `cke_o` rises, it stays high. At least ceil(T_CKE_NS/clock period) cycles of NOP follow before the first command, and that command is a precharge-all.
- R3: Commands are issued in this order: precharge-all; mode write to BA=2'b10; mode write to BA=2'b11; mode write to BA=2'b01; mode write to BA=2'b00 with DLL reset; precharge-all; NUM_REF auto-refreshes; mode write to BA=2'b00; two mode writes to BA=2'b01. No other command appears. `ba_o[0]` is BA0.
- R4: Command encodings with `cs_n_o` low, as {ras_n,cas_n,we_n}: NOP 3'b111, precharge 3'b010 with `addr_o[10]`=1, auto-refresh 3'b001 with address 0, mode write 3'b000.
- R5: Mode write payloads. The BA=2'b10 and BA=2'b11 writes carry EMR2_OPS and EMR3_OPS. The first BA=2'b01 write carries EMR1_OPS with bits 0, 7, 8 and 9 cleared. The DLL-reset write carries MR_OPS with bit 8 set; the later BA=2'b00 write carries MR_OPS with bit 8 cleared. The two final BA=2'b01 writes carry the first BA=2'b01 payload with bits 9:7 set to 3'b111, then 3'b000.
- R6: Spacing from one command to the next is at least the rounded-up cycle count of T_MRD_NS after a mode write, T_RP_NS after a precharge and T_RFC_NS after a refresh. Every gap is at least 2 cycles.
- R7: The calibration-default write (BA=2'b01, bits 9:7 = 3'b111) comes at least DLL_WAIT_CYC cycles after the DLL-reset write.
- R8: `init_done_o` rises no earlier than the mode-write gap after the last write. It then stays high with NOP on the bus.
- R9: Asserting `rst_ni` from any state, including after done, clears `init_done_o`, drops `cke_o` and returns the bus to NOP. A new run after that repeats the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_o | output | 1 | Memory clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address, bit 0 is BA0 |
| addr_o | output | 13 | Address bus |
| init_done_o | output | 1 | Sequence complete, sticky until reset |

## Verification
The checker watches every cycle for these: an idle bus while clock enable is low, clock enable never falling, only the four legal commands, precharge always selecting all banks, a NOP after every command, the DLL settling window before calibration entry, and done staying high over an idle bus. Only the bench scenarios can show the rest: the exact command order, the payload on each mode write, the exact length of each timed gap, and that a reset partway through or after completion restarts the whole sequence.

// File: rtl/ddr2_init_pkg.sv
`timescale 1ns/1ps
package ddr2_init_pkg;

  typedef struct packed {
    logic        cs_n;
    logic        ras_n;
    logic        cas_n;
    logic        we_n;
    logic [1:0]  ba;
    logic [12:0] addr;
  } ddr2_cmd_t;

  typedef enum logic [1:0] {
    ST_CLK_WAIT,
    ST_CKE_WAIT,
    ST_RUN,
    ST_DONE
  } init_state_e;

  localparam logic [12:0] BIT_DLL_DIS = 13'h0001;
  localparam logic [12:0] BIT_DLL_RST = 13'h0100;
  localparam logic [12:0] BITS_OCD    = 13'h0380;
  localparam logic [12:0] ADDR_ALLBNK = 13'h0400;

  localparam ddr2_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
                                    ba: 2'b00, addr: 13'h0000};

  function automatic ddr2_cmd_t mk_cmd(input logic ras_n, input logic cas_n, input logic we_n,
                                       input logic [1:0] ba, input logic [12:0] addr);
    ddr2_cmd_t c;
    c.cs_n  = 1'b0;
    c.ras_n = ras_n;
    c.cas_n = cas_n;
    c.we_n  = we_n;
    c.ba    = ba;
    c.addr  = addr;
    return c;
  endfunction

  // ns to cycles, rounded up, with a floor
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ps,
                                            input int unsigned min_cyc);
    int unsigned c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c < min_cyc) ? min_cyc : c;
  endfunction

endpackage

// File: rtl/ddr2_init_step_rom.sv
`timescale 1ns/1ps
module ddr2_init_step_rom
  import ddr2_init_pkg::*;
#(
  parameter int unsigned NUM_REF  = 2,
  parameter int unsigned STEP_W   = 4,
  parameter int unsigned GAP_W    = 16,
  parameter int unsigned MRD_CYC  = 2,
  parameter int unsigned RP_CYC   = 3,
  parameter int unsigned RFC_CYC  = 26,
  parameter logic [12:0] MR_OPS   = 13'h0000,
  parameter logic [12:0] EMR1_OPS = 13'h0000,
  parameter logic [12:0] EMR2_OPS = 13'h0000,
  parameter logic [12:0] EMR3_OPS = 13'h0000
) (
  input  logic [STEP_W-1:0] step_i,
  output ddr2_cmd_t         cmd_o,
  output logic [GAP_W-1:0]  gap_m1_o,
  output logic              dll_start_o,
  output logic              dll_wait_o
);

  localparam int unsigned REF_LO = 6;
  localparam int unsigned REF_HI = REF_LO + NUM_REF;
  localparam logic [12:0] EMR1_BASE = EMR1_OPS & ~(BIT_DLL_DIS | BITS_OCD);
  localparam logic [GAP_W-1:0] GAP_MRD = GAP_W'(MRD_CYC - 1);
  localparam logic [GAP_W-1:0] GAP_RP  = GAP_W'(RP_CYC - 1);
  localparam logic [GAP_W-1:0] GAP_RFC = GAP_W'(RFC_CYC - 1);

  logic [31:0] idx;
  assign idx = 32'(step_i);

  always_comb begin
    cmd_o       = CMD_NOP;
    gap_m1_o    = GAP_MRD;
    dll_start_o = 1'b0;
    dll_wait_o  = 1'b0;
    if (idx < REF_LO) begin
      case (idx)
        32'd0, 32'd5: begin
          cmd_o    = mk_cmd(1'b0, 1'b1, 1'b0, 2'b00, ADDR_ALLBNK);
          gap_m1_o = GAP_RP;
        end
        32'd1: cmd_o = mk_cmd(1'b0, 1'b0, 1'b0, 2'b10, EMR2_OPS);
        32'd2: cmd_o = mk_cmd(1'b0, 1'b0, 1'b0, 2'b11, EMR3_OPS);
        32'd3: cmd_o = mk_cmd(1'b0, 1'b0, 1'b0, 2'b01, EMR1_BASE);
        32'd4: begin
          cmd_o       = mk_cmd(1'b0, 1'b0, 1'b0, 2'b00, MR_OPS | BIT_DLL_RST);
          dll_start_o = 1'b1;
        end
        default: cmd_o = CMD_NOP;
      endcase
    end else if (idx < REF_HI) begin
      cmd_o    = mk_cmd(1'b0, 1'b0, 1'b1, 2'b00, 13'h0000);
      gap_m1_o = GAP_RFC;
    end else begin
      case (idx - REF_HI)
        32'd0: cmd_o = mk_cmd(1'b0, 1'b0, 1'b0, 2'b00, MR_OPS & ~BIT_DLL_RST);
        32'd1: begin
          cmd_o      = mk_cmd(1'b0, 1'b0, 1'b0, 2'b01, EMR1_BASE | BITS_OCD);
          dll_wait_o = 1'b1;
        end
        32'd2: cmd_o = mk_cmd(1'b0, 1'b0, 1'b0, 2'b01, EMR1_BASE);
        default: cmd_o = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddr2_init_dll_timer.sv
`timescale 1ns/1ps
module ddr2_init_dll_timer #(
  parameter int unsigned WAIT_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ready_o
);

  localparam int unsigned CW = $clog2(WAIT_CYC + 1);

  logic [CW-1:0] cnt_q;

  // 0 = not started; saturates at WAIT_CYC
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                         cnt_q <= '0;
    else if (start_i)                                    cnt_q <= CW'(1);
    else if (cnt_q != '0 && cnt_q != CW'(WAIT_CYC))      cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == CW'(WAIT_CYC));

endmodule

// File: rtl/ddr2_init_seq.sv
`timescale 1ns/1ps
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned T_STABLE_NS   = 200000,
  parameter int unsigned T_CKE_NS      = 400,
  parameter int unsigned T_MRD_NS      = 10,
  parameter int unsigned T_RP_NS       = 15,
  parameter int unsigned T_RFC_NS      = 128,
  parameter int unsigned NUM_REF       = 2,
  parameter int unsigned DLL_WAIT_CYC  = 200,
  parameter logic [12:0] MR_OPS        = 13'h0A53,
  parameter logic [12:0] EMR1_OPS      = 13'h0044,
  parameter logic [12:0] EMR2_OPS      = 13'h0000,
  parameter logic [12:0] EMR3_OPS      = 13'h0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic        cke_o,
  output logic        cs_n_o,
  output logic        ras_n_o,
  output logic        cas_n_o,
  output logic        we_n_o,
  output logic [1:0]  ba_o,
  output logic [12:0] addr_o,
  output logic        init_done_o
);

  localparam int unsigned STABLE_CYC = ns_to_cyc(T_STABLE_NS, CLK_PERIOD_PS, 1);
  localparam int unsigned CKE_CYC    = ns_to_cyc(T_CKE_NS, CLK_PERIOD_PS, 1);
  localparam int unsigned MRD_CYC    = ns_to_cyc(T_MRD_NS, CLK_PERIOD_PS, 2);
  localparam int unsigned RP_CYC     = ns_to_cyc(T_RP_NS, CLK_PERIOD_PS, 2);
  localparam int unsigned RFC_CYC    = ns_to_cyc(T_RFC_NS, CLK_PERIOD_PS, 2);
  localparam int unsigned NREF       = (NUM_REF < 2) ? 2 : NUM_REF;
  localparam int unsigned NUM_STEPS  = 9 + NREF;
  localparam int unsigned STEP_W     = $clog2(NUM_STEPS + 1);
  localparam int unsigned MAX_A      = (STABLE_CYC > CKE_CYC) ? STABLE_CYC : CKE_CYC;
  localparam int unsigned MAX_B      = (RFC_CYC > RP_CYC) ? RFC_CYC : RP_CYC;
  localparam int unsigned MAX_C      = (MAX_B > MRD_CYC) ? MAX_B : MRD_CYC;
  localparam int unsigned MAX_CYC    = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

  init_state_e         state_q;
  logic [STEP_W-1:0]   step_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                cke_q;
  logic                done_q;
  ddr2_cmd_t           cmd_q;

  ddr2_cmd_t           rom_cmd;
  logic [CNT_W-1:0]    rom_gap_m1;
  logic                rom_dll_start;
  logic                rom_dll_wait;
  logic                dll_ready;
  logic                last_step;
  logic                issue;

  ddr2_init_step_rom #(
    .NUM_REF  (NREF),
    .STEP_W   (STEP_W),
    .GAP_W    (CNT_W),
    .MRD_CYC  (MRD_CYC),
    .RP_CYC   (RP_CYC),
    .RFC_CYC  (RFC_CYC),
    .MR_OPS   (MR_OPS),
    .EMR1_OPS (EMR1_OPS),
    .EMR2_OPS (EMR2_OPS),
    .EMR3_OPS (EMR3_OPS)
  ) u_rom (
    .step_i      (step_q),
    .cmd_o       (rom_cmd),
    .gap_m1_o    (rom_gap_m1),
    .dll_start_o (rom_dll_start),
    .dll_wait_o  (rom_dll_wait)
  );

  ddr2_init_dll_timer #(
    .WAIT_CYC (DLL_WAIT_CYC)
  ) u_dll_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (issue && rom_dll_start),
    .ready_o (dll_ready)
  );

  assign last_step = (step_q == STEP_W'(NUM_STEPS));
  assign issue     = (state_q == ST_RUN) && (cnt_q == '0) && !last_step &&
                     (!rom_dll_wait || dll_ready);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CLK_WAIT;
      step_q  <= '0;
      cnt_q   <= CNT_W'(STABLE_CYC - 1);
      cke_q   <= 1'b0;
      done_q  <= 1'b0;
      cmd_q   <= CMD_NOP;
    end else begin
      cmd_q <= CMD_NOP;
      case (state_q)
        ST_CLK_WAIT: begin
          if (cnt_q == '0) begin
            state_q <= ST_CKE_WAIT;
            cnt_q   <= CNT_W'(CKE_CYC - 1);
            cke_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_CKE_WAIT: begin
          if (cnt_q == '0) state_q <= ST_RUN;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_RUN: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (last_step) begin
            state_q <= ST_DONE;
            done_q  <= 1'b1;
          end else if (issue) begin
            cmd_q  <= rom_cmd;
            cnt_q  <= rom_gap_m1;
            step_q <= step_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign cke_o       = cke_q;
  assign cs_n_o      = cmd_q.cs_n;
  assign ras_n_o     = cmd_q.ras_n;
  assign cas_n_o     = cmd_q.cas_n;
  assign we_n_o      = cmd_q.we_n;
  assign ba_o        = cmd_q.ba;
  assign addr_o      = cmd_q.addr;
  assign init_done_o = done_q;

endmodule

// File: rtl/ddr2_init_seq_chk.sv
`timescale 1ns/1ps
module ddr2_init_seq_chk #(
  parameter int unsigned DLL_WAIT_CYC = 200
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cke_i,
  input logic        cs_n_i,
  input logic        ras_n_i,
  input logic        cas_n_i,
  input logic        we_n_i,
  input logic [1:0]  ba_i,
  input logic [12:0] addr_i,
  input logic        done_i
);

  logic is_nop, is_pre, is_ref, is_mrs, dll_rst_wr, ocd_wr;
  logic        armed_q;
  logic [15:0] since_q;

  assign is_nop     = !cs_n_i &&  ras_n_i &&  cas_n_i &&  we_n_i;
  assign is_pre     = !cs_n_i && !ras_n_i &&  cas_n_i && !we_n_i;
  assign is_ref     = !cs_n_i && !ras_n_i && !cas_n_i &&  we_n_i;
  assign is_mrs     = !cs_n_i && !ras_n_i && !cas_n_i && !we_n_i;
  assign dll_rst_wr = is_mrs && ba_i == 2'b00 && addr_i[8];
  assign ocd_wr     = is_mrs && ba_i == 2'b01 && addr_i[9:7] == 3'b111;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      since_q <= '0;
    end else if (dll_rst_wr) begin
      armed_q <= 1'b1;
      since_q <= 16'd1;
    end else if (armed_q && since_q != 16'hFFFF) begin
      since_q <= since_q + 16'd1;
    end
  end

  AST_IDLE_CKE_LOW:   assert property (@(posedge clk_i) disable iff (!rst_ni) !cke_i |-> is_nop);  // R1
  AST_CKE_STAYS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni) cke_i |=> cke_i);    // R2
  AST_LEGAL_CMD:      assert property (@(posedge clk_i) disable iff (!rst_ni)
                                       is_nop || is_pre || is_ref || is_mrs);                      // R4
  AST_PRE_ALL_BANKS:  assert property (@(posedge clk_i) disable iff (!rst_ni) is_pre |-> addr_i[10]); // R4
  AST_CMD_THEN_NOP:   assert property (@(posedge clk_i) disable iff (!rst_ni) !is_nop |=> is_nop); // R6
  AST_DLL_SETTLE:     assert property (@(posedge clk_i) disable iff (!rst_ni)
                                       ocd_wr |-> (armed_q && 32'(since_q) >= DLL_WAIT_CYC));      // R7
  AST_DONE_STICKY:    assert property (@(posedge clk_i) disable iff (!rst_ni) done_i |=> done_i);  // R8
  AST_DONE_IDLE:      assert property (@(posedge clk_i) disable iff (!rst_ni) done_i |-> is_nop);  // R8

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.DLL_WAIT_CYC(DLL_WAIT_CYC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cke_i   (cke_o),
  .cs_n_i  (cs_n_o),
  .ras_n_i (ras_n_o),
  .cas_n_i (cas_n_o),
  .we_n_i  (we_n_o),
  .ba_i    (ba_o),
  .addr_i  (addr_o),
  .done_i  (init_done_o)
);

// File: tb/ddr2_init_seq_bench.sv
`timescale 1ns/1ps
module ddr2_init_seq_bench;

  localparam int unsigned NUM_REF  = 3;
  localparam logic [12:0] MR_OPS   = 13'h0A53;
  localparam logic [12:0] EMR1_OPS = 13'h0045;
  localparam logic [12:0] EMR2_OPS = 13'h0080;
  localparam logic [12:0] EMR3_OPS = 13'h0005;
  // 200 MHz: 200us, 400ns, 10ns, 15ns, 127.5ns->128ns rounded up
  localparam int STABLE = 40000;
  localparam int CKEW   = 80;
  localparam int MRD    = 2;
  localparam int RP     = 3;
  localparam int RFC    = 26;
  localparam int DLLW   = 200;
  localparam int NSTEP  = 9 + NUM_REF;
  localparam int K_NOP = 0, K_PRE = 1, K_REF = 2, K_MRS = 3, K_BAD = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [1:0]  ba;
  logic [12:0] addr;

  always #2.5 clk = ~clk;

  ddr2_init_seq #(
    .CLK_PERIOD_PS (5000),
    .T_STABLE_NS   (200000),
    .T_CKE_NS      (400),
    .T_MRD_NS      (10),
    .T_RP_NS       (15),
    .T_RFC_NS      (128),
    .NUM_REF       (NUM_REF),
    .DLL_WAIT_CYC  (DLLW),
    .MR_OPS        (MR_OPS),
    .EMR1_OPS      (EMR1_OPS),
    .EMR2_OPS      (EMR2_OPS),
    .EMR3_OPS      (EMR3_OPS)
  ) u_ddr2_init_seq (
    .clk_i (clk), .rst_ni (rst_ni), .cke_o (cke), .cs_n_o (cs_n), .ras_n_o (ras_n),
    .cas_n_o (cas_n), .we_n_o (we_n), .ba_o (ba), .addr_o (addr), .init_done_o (done)
  );

  int n_checks = 0;
  int n_err = 0;

  function automatic int kind_of(input logic c, input logic r, input logic a, input logic w);
    if (c) return K_NOP;
    case ({r, a, w})
      3'b111: return K_NOP;
      3'b010: return K_PRE;
      3'b001: return K_REF;
      3'b000: return K_MRS;
      default: return K_BAD;
    endcase
  endfunction

  // monitor
  int cyc, rise_cyc, done_cyc, n_log;
  int log_kind [32];
  int log_cyc  [32];
  logic [1:0]  log_ba   [32];
  logic [12:0] log_addr [32];
  bit cmd_after_done;

  always @(negedge clk) begin
    if (!rst_ni) begin
      cyc = 0; rise_cyc = -1; done_cyc = -1; n_log = 0; cmd_after_done = 0;
    end else begin
      cyc++;
      if (cke && rise_cyc < 0) rise_cyc = cyc;
      if (done && done_cyc < 0) done_cyc = cyc;
      if (kind_of(cs_n, ras_n, cas_n, we_n) != K_NOP) begin
        if (done_cyc >= 0) cmd_after_done = 1;
        if (n_log < 32) begin
          log_kind[n_log] = kind_of(cs_n, ras_n, cas_n, we_n);
          log_cyc[n_log]  = cyc;
          log_ba[n_log]   = ba;
          log_addr[n_log] = addr;
        end
        n_log++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) tick();
    rst_ni = 1'b1;
  endtask

  function automatic int exp_kind(input int i);
    if (i == 0 || i == 5) return K_PRE;
    if (i >= 6 && i < 6 + NUM_REF) return K_REF;
    return K_MRS;
  endfunction

  function automatic logic [1:0] exp_ba(input int i);
    int j = i - (6 + NUM_REF);
    case (i)
      1: return 2'b10;
      2: return 2'b11;
      3: return 2'b01;
      default: return (j == 1 || j == 2) ? 2'b01 : 2'b00;
    endcase
  endfunction

  function automatic logic [12:0] exp_addr(input int i);
    logic [12:0] e1 = EMR1_OPS & ~13'h0381;
    int j = i - (6 + NUM_REF);
    if (exp_kind(i) == K_PRE) return 13'h0400;
    if (exp_kind(i) == K_REF) return 13'h0000;
    case (i)
      1: return EMR2_OPS;
      2: return EMR3_OPS;
      3: return e1;
      4: return MR_OPS | 13'h0100;
      default: ;
    endcase
    case (j)
      0: return MR_OPS & ~13'h0100;
      1: return e1 | 13'h0380;
      default: return e1;
    endcase
  endfunction

  function automatic int exp_gap(input int i);
    case (exp_kind(i))
      K_PRE: return RP;
      K_REF: return RFC;
      default: return MRD;
    endcase
  endfunction

  task automatic t_reset_state();
    do_reset();
    tick();
    chk(cke == 1'b0, "R1", "cke after reset", cke, 0);
    chk(kind_of(cs_n, ras_n, cas_n, we_n) == K_NOP, "R1", "bus idle after reset",
        kind_of(cs_n, ras_n, cas_n, we_n), K_NOP);
    chk(done == 1'b0, "R9", "done after reset", done, 0);
    repeat (200) tick();
    chk(cke == 1'b0, "R1", "cke still low early", cke, 0);
  endtask

  task automatic t_full_sequence();
    int ocd_i = 6 + NUM_REF + 1;
    do_reset();
    while (!done) tick();
    chk(rise_cyc >= STABLE, "R1", "cycles before cke rise", rise_cyc, STABLE);
    chk(n_log >= 1 && log_cyc[0] - rise_cyc >= CKEW, "R2", "nop cycles after cke rise",
        log_cyc[0] - rise_cyc, CKEW);
    chk(log_kind[0] == K_PRE, "R2", "first command kind", log_kind[0], K_PRE);
    chk(n_log == NSTEP, "R3", "command count", n_log, NSTEP);
    for (int i = 0; i < NSTEP && i < n_log; i++) begin
      chk(log_kind[i] == exp_kind(i), "R4", $sformatf("kind of step %0d", i), log_kind[i], exp_kind(i));
      chk(log_ba[i] == exp_ba(i), "R3", $sformatf("bank of step %0d", i), log_ba[i], exp_ba(i));
      chk(log_addr[i] == exp_addr(i), "R5", $sformatf("addr of step %0d", i), log_addr[i], exp_addr(i));
      if (i + 1 < n_log)
        chk(log_cyc[i+1] - log_cyc[i] >= exp_gap(i), "R6", $sformatf("gap after step %0d", i),
            log_cyc[i+1] - log_cyc[i], exp_gap(i));
    end
    if (n_log > ocd_i)
      chk(log_cyc[ocd_i] - log_cyc[4] >= DLLW, "R7", "dll reset to calibration",
          log_cyc[ocd_i] - log_cyc[4], DLLW);
    if (n_log >= 1)
      chk(done_cyc - log_cyc[n_log-1] >= MRD, "R8", "done after last write",
          done_cyc - log_cyc[n_log-1], MRD);
    repeat (60) tick();
    chk(done == 1'b1, "R8", "done sticky", done, 1);
    chk(!cmd_after_done, "R8", "commands after done", cmd_after_done, 0);
    chk(cke == 1'b1, "R2", "cke held high", cke, 1);
  endtask

  task automatic t_reset_after_done();
    rst_ni = 1'b0;
    #1;
    chk(done == 1'b0, "R9", "done cleared by reset", done, 0);
    chk(cke == 1'b0, "R9", "cke dropped by reset", cke, 0);
    tick();
    rst_ni = 1'b1;
  endtask

  task automatic t_reset_midrun();
    do_reset();
    while (n_log < 7) tick();
    rst_ni = 1'b0;
    #1;
    chk(cke == 1'b0, "R9", "cke after mid-run reset", cke, 0);
    chk(done == 1'b0, "R9", "done after mid-run reset", done, 0);
    chk(kind_of(cs_n, ras_n, cas_n, we_n) == K_NOP, "R9", "bus after mid-run reset",
        kind_of(cs_n, ras_n, cas_n, we_n), K_NOP);
    tick();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    t_reset_state();
    t_full_sequence();
    t_reset_after_done();
    t_reset_midrun();
    t_full_sequence();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule